// File: doc/BRIEF.md
# Scaled Index Address Generator

This block forms a memory address from up to three terms: a base register value, an index register value shifted left by a small scale amount, and a signed constant offset. A two-bit mode field selects whether the index term and the offset term take part, so one datapath covers four forms: base plus offset, base plus index, base plus scaled index, and base plus scaled index plus offset. The offset is either a short immediate, sign-extended to full width, or a full-width immediate.

The sum is available combinationally on `ea_o` for a memory pipeline that needs the address in the same cycle. It is also captured in an output register on a valid pulse. That registered copy is the load-effective-address result: the address itself, ready to be written to a register, with no memory access involved. All sums wrap modulo 2^ADDR_W.

Top module: `scaled_agen`

## Requirements
- R1: With mode = 2'b10 (offset enabled, index disabled) and a full-width offset, `ea_o` equals `base_val + disp_val`.
- R2: With mode = 2'b01 (index enabled, offset disabled) and scale_code 0, `ea_o` equals `base_val + index_val`.
- R3: With the index term enabled, scale_code values 0, 1, 2 and 3 shift `index_val` left by 0, 1, 2 and 3 bits (×1, ×2, ×4, ×8). Bits shifted past bit 31 are lost.
- R4: With mode = 2'b11, `ea_o` equals `base_val + (index_val << scale_code) + offset`.
- R5: With `disp_long` = 0, the offset is `disp_val[7:0]` sign-extended from bit 7, and `disp_val[31:8]` has no effect.
- R6: With `disp_long` = 1, all 32 bits of `disp_val` are used as the offset.
- R7: When mode bit 0 (index enable) is 0, `index_val` and `scale_code` have no effect on `ea_o`.
- R8: When mode bit 1 (offset enable) is 0, `disp_val` and `disp_long` have no effect on `ea_o`. With mode = 2'b00, `ea_o` equals `base_val`.
- R9: Every addition wraps modulo 2^32.
- R10: When `in_valid` is high at a rising clock edge, `lea_q` takes that cycle's `ea_o` and `out_valid` is high for the following cycle. When `in_valid` is low at an edge, `out_valid` goes low and `lea_q` keeps its value.
- R11: While `rst_n` is low, `out_valid` and `lea_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture request for the result register |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index left-shift amount |
| disp_val | input | 32 | Offset immediate |
| disp_long | input | 1 | 1: full-width offset, 0: short sign-extended offset |
| mode | input | 2 | Bit 0 enables the index term, bit 1 enables the offset term |
| ea_o | output | 32 | Combinational effective address |
| lea_q | output | 32 | Registered load-effective-address result |
| out_valid | output | 1 | High for the cycle after each captured request |

## Verification
The bench builds the block at its default parameters: a 32-bit address, an 8-bit short offset and a 2-bit scale code. This makes all four shift amounts reachable, including the largest, which drops the index's top three bits. The short offset can reach both 0x7F and 0x80, so both sign-extension polarities are exercised. Sums can also cross 2^32, so wrap-around is covered in both the combinational and the registered paths.

// File: rtl/agen_pkg.sv
package agen_pkg;
    localparam int AGEN_ADDR_W  = 32;
    localparam int AGEN_SHORT_W = 8;
    localparam int AGEN_SCALE_W = 2;

    // mode field: bit 1 enables the offset term, bit 0 the index term
    typedef struct packed {
        logic use_disp;
        logic use_index;
    } agen_mode_t;
endpackage

// File: rtl/agen_index_scale.sv
module agen_index_scale #(
    parameter int ADDR_W  = agen_pkg::AGEN_ADDR_W,
    parameter int SCALE_W = agen_pkg::AGEN_SCALE_W
) (
    input  logic [ADDR_W-1:0]  idx_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic               en_i,
    output logic [ADDR_W-1:0]  term_o
);
    localparam int NUM_SHIFTS = 1 << SCALE_W;

    logic [ADDR_W-1:0] cand [NUM_SHIFTS];

    // one candidate per shift amount; the scale code picks among them
    for (genvar g = 0; g < NUM_SHIFTS; g++) begin : g_shift
        assign cand[g] = idx_i << g;
    end

    always_comb begin
        term_o = en_i ? cand[scale_i] : '0;
    end
endmodule

// File: rtl/agen_disp_ext.sv
module agen_disp_ext #(
    parameter int ADDR_W  = agen_pkg::AGEN_ADDR_W,
    parameter int SHORT_W = agen_pkg::AGEN_SHORT_W
) (
    input  logic [ADDR_W-1:0] disp_i,
    input  logic              long_i,
    input  logic              en_i,
    output logic [ADDR_W-1:0] term_o
);
    localparam int EXT_W = ADDR_W - SHORT_W;

    logic [ADDR_W-1:0] short_ext;

    always_comb begin
        short_ext = {{EXT_W{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
        if (!en_i)
            term_o = '0;
        else if (long_i)
            term_o = disp_i;
        else
            term_o = short_ext;
    end
endmodule

// File: rtl/scaled_agen.sv
module scaled_agen #(
    parameter int ADDR_W  = agen_pkg::AGEN_ADDR_W,
    parameter int SHORT_W = agen_pkg::AGEN_SHORT_W,
    parameter int SCALE_W = agen_pkg::AGEN_SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [ADDR_W-1:0]  index_val,
    input  logic [SCALE_W-1:0] scale_code,
    input  logic [ADDR_W-1:0]  disp_val,
    input  logic               disp_long,
    input  logic [1:0]         mode,
    output logic [ADDR_W-1:0]  ea_o,
    output logic [ADDR_W-1:0]  lea_q,
    output logic               out_valid
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } stage_t;

    agen_pkg::agen_mode_t mode_s;
    logic [ADDR_W-1:0]    idx_term;
    logic [ADDR_W-1:0]    disp_term;
    stage_t               st_d, st_q;

    assign mode_s = agen_pkg::agen_mode_t'(mode);

    agen_index_scale #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_scale (
        .idx_i   (index_val),
        .scale_i (scale_code),
        .en_i    (mode_s.use_index),
        .term_o  (idx_term)
    );

    agen_disp_ext #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_disp (
        .disp_i  (disp_val),
        .long_i  (disp_long),
        .en_i    (mode_s.use_disp),
        .term_o  (disp_term)
    );

    always_comb begin
        ea_o     = base_val + idx_term + disp_term;
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid)
            st_d.addr = ea_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign lea_q     = st_q.addr;
    assign out_valid = st_q.vld;
endmodule

// File: rtl/scaled_agen_chk.sv
module scaled_agen_chk #(
    parameter int ADDR_W  = 32,
    parameter int SCALE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [ADDR_W-1:0]  base_val,
    input logic [ADDR_W-1:0]  index_val,
    input logic [SCALE_W-1:0] scale_code,
    input logic [1:0]         mode,
    input logic [ADDR_W-1:0]  ea_o,
    input logic [ADDR_W-1:0]  lea_q,
    input logic               out_valid
);
    // R10
    vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (lea_q == $past(ea_o)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(lea_q));

    // R8
    base_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (ea_o == base_val));

    // R2
    plain_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && scale_code == '0) |-> (ea_o == base_val + index_val));

    // R11
    reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && lea_q == '0));
endmodule

bind scaled_agen scaled_agen_chk #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .base_val   (base_val),
    .index_val  (index_val),
    .scale_code (scale_code),
    .mode       (mode),
    .ea_o       (ea_o),
    .lea_q      (lea_q),
    .out_valid  (out_valid)
);

// File: tb/tb_scaled_agen.sv
module tb_scaled_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic [1:0]  scale_code = '0;
    logic [31:0] disp_val = '0;
    logic        disp_long = 1'b0;
    logic [1:0]  mode = '0;
    logic [31:0] ea_o, lea_q;
    logic        out_valid;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    scaled_agen dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
        .index_val(index_val), .scale_code(scale_code), .disp_val(disp_val),
        .disp_long(disp_long), .mode(mode), .ea_o(ea_o), .lea_q(lea_q),
        .out_valid(out_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [31:0] b, input logic [31:0] x,
                         input logic [1:0] s, input logic [31:0] d, input logic lg);
        @(negedge clk);
        mode = m; base_val = b; index_val = x; scale_code = s; disp_val = d; disp_long = lg;
        #1;
    endtask

    task automatic t_reset;
        check("R11 out_valid", {31'b0, out_valid}, 32'h0);
        check("R11 lea_q", lea_q, 32'h0);
    endtask

    task automatic t_base_disp;
        drive(2'b10, 32'h0000_1000, 32'hDEAD_BEEF, 2'd3, 32'h0000_0234, 1'b1);
        check("R1 base+disp", ea_o, 32'h0000_1234);
    endtask

    task automatic t_base_index;
        drive(2'b01, 32'h0000_0100, 32'h0000_0023, 2'd0, 32'h5555_5555, 1'b1);
        check("R2 base+index", ea_o, 32'h0000_0123);
    endtask

    task automatic t_scales;
        for (int s = 0; s < 4; s++) begin
            drive(2'b01, 32'h0000_1000, 32'h0000_0005, s[1:0], 32'h0, 1'b0);
            check("R3 scale", ea_o, 32'h0000_1000 + (32'h5 << s));
        end
        drive(2'b01, 32'h0, 32'hF000_0001, 2'd3, 32'h0, 1'b0);
        check("R3 shifted-out bits", ea_o, 32'h8000_0008);
    endtask

    task automatic t_full;
        drive(2'b11, 32'h0001_0000, 32'h0000_0010, 2'd2, 32'h0000_000C, 1'b1);
        check("R4 full form", ea_o, 32'h0001_004C);
    endtask

    task automatic t_short_disp;
        drive(2'b10, 32'h0000_1000, 32'h0, 2'd0, 32'h1234_5680, 1'b0);
        check("R5 short negative", ea_o, 32'h0000_0F80);
        drive(2'b10, 32'h0000_1000, 32'h0, 2'd0, 32'hFFFF_FF7F, 1'b0);
        check("R5 short positive", ea_o, 32'h0000_107F);
    endtask

    task automatic t_long_disp;
        drive(2'b10, 32'h0000_1000, 32'h0, 2'd0, 32'hFFFF_FF80, 1'b1);
        check("R6 long negative", ea_o, 32'h0000_0F80);
        drive(2'b10, 32'h0000_0000, 32'h0, 2'd0, 32'h1234_5680, 1'b1);
        check("R6 long upper bits", ea_o, 32'h1234_5680);
    endtask

    task automatic t_disabled_terms;
        drive(2'b10, 32'h0000_0040, 32'hFFFF_FFFF, 2'd3, 32'h0000_0004, 1'b1);
        check("R7 index ignored", ea_o, 32'h0000_0044);
        drive(2'b01, 32'h0000_0040, 32'h0000_0002, 2'd1, 32'h7777_7777, 1'b0);
        check("R8 disp ignored", ea_o, 32'h0000_0044);
        drive(2'b00, 32'hCAFE_0000, 32'h1111_1111, 2'd2, 32'h2222_2222, 1'b1);
        check("R8 base only", ea_o, 32'hCAFE_0000);
    endtask

    task automatic t_wrap;
        drive(2'b10, 32'hFFFF_FFF0, 32'h0, 2'd0, 32'h0000_0020, 1'b1);
        check("R9 wrap", ea_o, 32'h0000_0010);
        drive(2'b11, 32'h8000_0000, 32'h1000_0000, 2'd3, 32'h0000_0001, 1'b0);
        check("R9 wrap full", ea_o, 32'h0000_0001);
    endtask

    task automatic t_register;
        drive(2'b11, 32'h0000_2000, 32'h0000_0003, 2'd2, 32'h0000_00F0, 1'b0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        base_val = 32'h9999_0000;
        #1;
        check("R10 out_valid high", {31'b0, out_valid}, 32'h1);
        check("R10 lea_q captured", lea_q, 32'h0000_1FFC);
        @(negedge clk); #1;
        check("R10 out_valid low", {31'b0, out_valid}, 32'h0);
        check("R10 lea_q held", lea_q, 32'h0000_1FFC);
        drive(2'b10, 32'hFFFF_FFFF, 32'h0, 2'd0, 32'h0000_0002, 1'b1);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check("R10 R9 registered wrap", lea_q, 32'h0000_0001);
    endtask

    initial begin
        #3000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk); #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_base_disp();
        t_base_index();
        t_scales();
        t_full();
        t_short_disp();
        t_long_disp();
        t_disabled_terms();
        t_wrap();
        t_register();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule